// File: doc/BRIEF.md
# Probabilistic Neighbour Refresh Scheduler

This block sits beside a DRAM bank scheduler and watches for rows being closed. Each time a row-close event reaches it, it flips a biased coin driven by an internal pseudo-random generator. With a programmable probability it asks for an extra activation of a row next to the one just closed. Upper and lower neighbours are equally likely. A small p, around one in a thousand, keeps the added traffic low. Because the block keeps no count of activations per row, its area does not grow with the number of rows. The price is that protection is only statistical: a neighbour is not certain to be refreshed in time, but the chance of a disturbance error becomes very small.

The refresh request leaves on a valid/ready stream. Once `req_valid` is raised, the request and its row stay unchanged until `req_ready` is sampled high. The block holds one request at a time. A close event that arrives while a request is waiting with `req_ready` low is dropped, and a saturating counter records it. A close that arrives in the very cycle a request is handed over is evaluated normally, so a consumer that keeps `req_ready` high never causes a drop. The close input has no ready, because a bank cannot stall a precharge.

Top module: `nbr_refresh_sched`

## Requirements
- R1: After reset, `req_valid` is 0, `drop_count` is 0, and the generator state equals the SEED_INIT parameter.
- R2: The generator is an LFSR_W-bit Galois register that shifts right once per clock. When the bit shifted out is 1, the tap mask is XORed into the shifted value; the default 32-bit mask is 32'h80200003. A cycle with `seed_load` high loads `seed` in place of shifting, and a zero seed is replaced by 1.
- R3: A close event that is accepted comes up heads when the low PROB_W bits of the generator state, read as an unsigned number, are below `prob`. These are the bits the state holds in the cycle of the close. With `prob` = 0 no request is ever made.
- R4: For an interior row, generator bit PROB_W in the cycle of the close picks the neighbour: 1 gives row+1, 0 gives row-1.
- R5: Row 0 always maps to row 1, and row NUM_ROWS-1 always maps to row NUM_ROWS-2, whatever the direction bit is.
- R6: A heads decision raises `req_valid` in the cycle after the close. While `req_ready` is low, `req_valid` and `req_row` hold. The cycle after a transfer, `req_valid` is low unless a new request was made.
- R7: A close in a cycle where `req_valid` and `req_ready` are both high is evaluated like any other close, so requests can be made on back-to-back cycles.
- R8: A close while `req_valid` is high and `req_ready` is low is dropped. The pending request does not change, and `drop_count` goes up by one, stopping at its all-ones value.
- R9: A tails decision leaves no request behind. `req_row` is always below NUM_ROWS while `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed` into the generator this cycle |
| seed | input | LFSR_W | Seed value (0 is replaced by 1) |
| prob | input | PROB_W | Heads probability as a fraction of 2^PROB_W |
| close_valid | input | 1 | A row of the bank is being closed this cycle |
| close_row | input | ROW_W | Index of the row being closed |
| req_valid | output | 1 | Extra activation request is pending |
| req_ready | input | 1 | Consumer accepts the request this cycle |
| req_row | output | ROW_W | Neighbour row to activate |
| drop_count | output | CNT_W | Saturating count of dropped close events |

## Verification
The bench builds the block with NUM_ROWS = 1000, which is not a power of two. Both edge rows and the bound on `req_row` can then be reached by ordinary row indices, and an off-by-one in the last-row compare cannot be hidden by address wrap. CNT_W = 4 makes the drop counter saturate after fifteen drops, so the saturation limit is reached within a few dozen cycles. The generator stays at the default 32-bit width with PROB_W = 16. Because the bench models every coin flip and direction bit exactly from the loaded seed, `prob` values of 0, all-ones and mid-range all check exact outcomes, not statistics.

// File: rtl/nrs_pkg.sv
package nrs_pkg;

  typedef enum logic {
    NBR_BELOW = 1'b0,
    NBR_ABOVE = 1'b1
  } nbr_dir_e;

  // Galois right-shift tap masks for maximal-length sequences.
  function automatic logic [63:0] lfsr_tap_mask(input int width);
    logic [63:0] m;
    case (width)
      16:      m = 64'h0000_0000_0000_B400;
      20:      m = 64'h0000_0000_0009_0000;
      24:      m = 64'h0000_0000_00E1_0000;
      28:      m = 64'h0000_0000_0900_0000;
      32:      m = 64'h0000_0000_8020_0003;
      default: m = 64'h0000_0000_8020_0003;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/nrs_lfsr.sv
module nrs_lfsr #(
  parameter int           W         = 32,
  parameter logic [W-1:0] SEED_INIT = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  import nrs_pkg::*;

  localparam logic [63:0]  MASK64 = lfsr_tap_mask(W);
  localparam logic [W-1:0] MASK   = MASK64[W-1:0];
  localparam logic [W-1:0] ONE    = W'(1);

  logic [W-1:0] shifted;
  logic [W-1:0] seed_safe;

  assign shifted   = (state >> 1) ^ ({W{state[0]}} & MASK);
  assign seed_safe = (seed == '0) ? ONE : seed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEED_INIT;
    end else if (load) begin
      state <= seed_safe;
    end else begin
      state <= shifted;
    end
  end
endmodule

// File: rtl/nrs_pick.sv
module nrs_pick #(
  parameter int NUM_ROWS = 32768,
  parameter int ROW_W    = 15,
  parameter int PROB_W   = 16
) (
  input  logic [PROB_W-1:0] rnd,
  input  logic              dir_bit,
  input  logic [PROB_W-1:0] prob,
  input  logic [ROW_W-1:0]  row,
  output logic              heads,
  output logic [ROW_W-1:0]  target
);
  import nrs_pkg::*;

  localparam logic [ROW_W-1:0] FIRST_ROW = '0;
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(NUM_ROWS - 1);
  localparam logic [ROW_W-1:0] STEP      = ROW_W'(1);

  nbr_dir_e dir;

  assign heads = (rnd < prob);
  assign dir   = nbr_dir_e'(dir_bit);

  always_comb begin
    if (row == FIRST_ROW) begin
      target = FIRST_ROW + STEP;
    end else if (row == LAST_ROW) begin
      target = LAST_ROW - STEP;
    end else if (dir == NBR_ABOVE) begin
      target = row + STEP;
    end else begin
      target = row - STEP;
    end
  end
endmodule

// File: rtl/nrs_slot.sv
module nrs_slot #(
  parameter int ROW_W = 15,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_valid,
  input  logic             heads,
  input  logic [ROW_W-1:0] target,
  input  logic             req_ready,
  output logic             req_valid,
  output logic [ROW_W-1:0] req_row,
  output logic [CNT_W-1:0] drop_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic stalled;
  logic handed_over;

  assign stalled     = req_valid & ~req_ready;
  assign handed_over = req_valid &  req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_row    <= '0;
      drop_count <= '0;
    end else if (close_valid && stalled) begin
      if (drop_count != CNT_MAX) begin
        drop_count <= drop_count + CNT_ONE;
      end
    end else begin
      if (handed_over) begin
        req_valid <= 1'b0;
      end
      if (close_valid && heads) begin
        req_valid <= 1'b1;
        req_row   <= target;
      end
    end
  end
endmodule

// File: rtl/nbr_refresh_sched.sv
module nbr_refresh_sched #(
  parameter int                NUM_ROWS  = 32768,
  parameter int                ROW_W     = $clog2(NUM_ROWS),
  parameter int                PROB_W    = 16,
  parameter int                LFSR_W    = 32,
  parameter int                CNT_W     = 16,
  parameter logic [LFSR_W-1:0] SEED_INIT = LFSR_W'(32'hACE1_2BAD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  input  logic [PROB_W-1:0] prob,
  input  logic              close_valid,
  input  logic [ROW_W-1:0]  close_row,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ROW_W-1:0]  req_row,
  output logic [CNT_W-1:0]  drop_count
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [PROB_W-1:0] coin_val;
  logic              dir_bit;
  logic              heads;
  logic [ROW_W-1:0]  target;
  logic              lfsr_unused_bits;

  assign coin_val         = lfsr_q[PROB_W-1:0];
  assign dir_bit          = lfsr_q[PROB_W];
  assign lfsr_unused_bits = ^lfsr_q;

  nrs_lfsr #(
    .W         (LFSR_W),
    .SEED_INIT (SEED_INIT)
  ) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (seed_load),
    .seed  (seed),
    .state (lfsr_q)
  );

  nrs_pick #(
    .NUM_ROWS (NUM_ROWS),
    .ROW_W    (ROW_W),
    .PROB_W   (PROB_W)
  ) u_pick (
    .rnd     (coin_val),
    .dir_bit (dir_bit),
    .prob    (prob),
    .row     (close_row),
    .heads   (heads),
    .target  (target)
  );

  nrs_slot #(
    .ROW_W (ROW_W),
    .CNT_W (CNT_W)
  ) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .close_valid (close_valid),
    .heads       (heads),
    .target      (target),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_row     (req_row),
    .drop_count  (drop_count)
  );

endmodule

// File: rtl/nbr_refresh_sched_chk.sv
module nbr_refresh_sched_chk #(
  parameter int NUM_ROWS = 32768,
  parameter int ROW_W    = 15,
  parameter int PROB_W   = 16,
  parameter int CNT_W    = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PROB_W-1:0] prob,
  input logic              close_valid,
  input logic [ROW_W-1:0]  close_row,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ROW_W-1:0]  req_row,
  input logic [CNT_W-1:0]  drop_count
);
  localparam logic [ROW_W-1:0] LAST = ROW_W'(NUM_ROWS - 1);

  // R6
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_row));

  // R9
  row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_row <= LAST);

  // R8
  drop_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && req_valid && !req_ready && drop_count != '1
    |=> drop_count == $past(drop_count) + CNT_W'(1));

  // R8
  drop_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_count == '1 |=> drop_count == '1);

  // R5
  first_row_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !(req_valid && !req_ready) && close_row == '0
    |=> !req_valid || req_row == ROW_W'(1));

  // R5
  last_row_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !(req_valid && !req_ready) && close_row == LAST
    |=> !req_valid || req_row == LAST - ROW_W'(1));

  // R3
  zero_prob_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !(req_valid && !req_ready) && prob == '0 |=> !req_valid);

  // R4
  adjacent_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_valid && !(req_valid && !req_ready)
    |=> !req_valid || req_row == $past(close_row) + ROW_W'(1)
                   || req_row == $past(close_row) - ROW_W'(1));

  // R6
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !close_valid && !(req_valid && !req_ready) |=> !req_valid);
endmodule

bind nbr_refresh_sched nbr_refresh_sched_chk #(
  .NUM_ROWS (NUM_ROWS),
  .ROW_W    (ROW_W),
  .PROB_W   (PROB_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .prob        (prob),
  .close_valid (close_valid),
  .close_row   (close_row),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_row     (req_row),
  .drop_count  (drop_count)
);

// File: tb/nbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module nbr_refresh_sched_tb;
  localparam int          NUM_ROWS = 1000;
  localparam int          ROW_W    = 10;
  localparam int          PROB_W   = 16;
  localparam int          LFSR_W   = 32;
  localparam int          CNT_W    = 4;
  localparam logic [31:0] SEED0    = 32'hACE1_2BAD;
  localparam logic [31:0] TAPS     = 32'h8020_0003;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              seed_load = 1'b0;
  logic [31:0]       seed = '0;
  logic [15:0]       prob = '0;
  logic              close_valid = 1'b0;
  logic [ROW_W-1:0]  close_row = '0;
  logic              req_valid;
  logic              req_ready = 1'b0;
  logic [ROW_W-1:0]  req_row;
  logic [CNT_W-1:0]  drop_count;

  always #2 clk = ~clk;

  nbr_refresh_sched #(
    .NUM_ROWS (NUM_ROWS), .ROW_W (ROW_W), .PROB_W (PROB_W),
    .LFSR_W (LFSR_W), .CNT_W (CNT_W), .SEED_INIT (SEED0)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .seed_load (seed_load), .seed (seed),
    .prob (prob), .close_valid (close_valid), .close_row (close_row),
    .req_valid (req_valid), .req_ready (req_ready), .req_row (req_row),
    .drop_count (drop_count)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  int ready_mode = 1;   // 0 low, 1 high, 2 random
  int n_hs = 0;
  int n_issued = 0;

  // reference model state
  logic [31:0]      m_s = SEED0;
  logic             m_valid = 1'b0;
  logic [CNT_W-1:0] m_cnt = '0;
  int               exp_rows[$];
  string            exp_tags[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step_lfsr(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? TAPS : 32'h0);
  endfunction

  // Model: R2 generator, R3 coin, R4/R5 neighbour, R6/R7/R8 slot
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = SEED0; m_valid = 1'b0; m_cnt = '0;
    end else begin
      bit stalled;
      stalled = m_valid && !req_ready;
      if (close_valid && stalled) begin
        if (m_cnt != '1) m_cnt = m_cnt + 1'b1;
      end else begin
        if (m_valid && req_ready) m_valid = 1'b0;
        if (close_valid && (m_s[15:0] < prob)) begin
          int r;
          string tg;
          if (close_row == 0) begin r = 1; tg = "R5"; end
          else if (close_row == NUM_ROWS - 1) begin r = NUM_ROWS - 2; tg = "R5"; end
          else begin r = m_s[16] ? close_row + 1 : close_row - 1; tg = "R4"; end
          m_valid = 1'b1;
          exp_rows.push_back(r);
          exp_tags.push_back(tg);
          n_issued++;
        end
      end
      m_s = seed_load ? ((seed == 0) ? 32'd1 : seed) : step_lfsr(m_s);
    end
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_valid == m_valid, "R2/R3/R6", "req_valid", req_valid, m_valid);
      check(drop_count == m_cnt, "R8", "drop_count", drop_count, m_cnt);
      if (req_valid && req_ready) begin
        n_hs++;
        if (exp_rows.size() == 0) begin
          check(1'b0, "R9", "unexpected request row", req_row, -1);
        end else begin
          int e;
          string t;
          e = exp_rows.pop_front();
          t = exp_tags.pop_front();
          check(req_row == e, t, "req_row", req_row, e);
        end
      end
    end
  end

  // Ready driver
  always @(posedge clk) begin
    #1;
    case (ready_mode)
      0: req_ready = 1'b0;
      1: req_ready = 1'b1;
      default: req_ready = ($urandom_range(0, 2) != 0);
    endcase
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic close_at(input int row);
    close_valid = 1'b1; close_row = ROW_W'(row); tick(); close_valid = 1'b0;
  endtask

  task automatic load_seed(input logic [31:0] v);
    seed = v; seed_load = 1'b1; tick(); seed_load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int base;
    repeat (3) tick();
    // R1: reset state
    check(req_valid == 1'b0, "R1", "req_valid in reset", req_valid, 0);
    check(drop_count == 0, "R1", "drop_count in reset", drop_count, 0);
    rst_n = 1'b1;
    tick();

    // R3/R9: zero probability gives no requests
    prob = 16'h0000; ready_mode = 1;
    base = n_hs;
    for (int i = 0; i < 200; i++) close_at(1 + (i * 7) % (NUM_ROWS - 2));
    repeat (3) tick();
    check(n_hs == base, "R3", "requests with prob 0", n_hs - base, 0);

    // R7/R4: closes every cycle, always ready, near-certain heads
    prob = 16'hFFFF;
    base = n_issued;
    close_valid = 1'b1;
    for (int i = 0; i < 300; i++) begin
      close_row = ROW_W'(5 + (i * 13) % 980); tick();
    end
    close_valid = 1'b0;
    repeat (3) tick();
    check(n_issued - base >= 299, "R7", "back-to-back requests", n_issued - base, 300);
    check(n_hs == n_issued, "R7", "transfers vs issued", n_hs, n_issued);

    // R5: edge rows, several seeds
    for (int k = 0; k < 8; k++) begin
      load_seed(32'h1357_0000 + k * 32'h0101_0F0F);
      close_at(0); tick();
      close_at(NUM_ROWS - 1); tick();
    end
    repeat (3) tick();

    // R2: zero seed replaced by 1
    load_seed(32'h0);
    prob = 16'h8000;
    for (int i = 0; i < 100; i++) close_at(100 + i);
    repeat (3) tick();

    // R8: stalled consumer drops and saturates
    ready_mode = 0; prob = 16'hFFFF;
    repeat (2) tick();
    close_at(500);
    for (int i = 0; i < 25; i++) close_at(600 + i);
    tick();
    check(drop_count == 4'hF, "R8", "saturated drop_count", drop_count, 15);
    check(req_valid == 1'b1, "R8", "pending kept after drops", req_valid, 1);
    ready_mode = 1;
    repeat (4) tick();

    // R6: random back-pressure, mid probability, random rows
    ready_mode = 2; prob = 16'h4000;
    load_seed(32'hDEAD_BEEF);
    for (int i = 0; i < 3000; i++) begin
      close_valid = ($urandom_range(0, 1) == 1);
      close_row = ROW_W'($urandom_range(0, NUM_ROWS - 1));
      tick();
    end
    close_valid = 1'b0;
    ready_mode = 1;
    repeat (5) tick();
    check(exp_rows.size() == 0, "R6", "outstanding expected items", exp_rows.size(), 0);
    finish_run();
  end
endmodule